// File: doc/BRIEF.md
# Buck Converter Startup and Fault Sequencer

This block is the digital supervisor of a synchronous step-down converter. It receives a supply-good flag, a shutdown request, an over-current comparator flag (qualified by a low-side conduction indicator), a digitized feedback code and a digitized threshold-pin code. From these it walks the converter through five phases: idle, threshold sampling, soft-start, run and hiccup. It produces the reference code fed to the error amplifier, the gate-enable mode for the two power switches, and a few status flags.

Before every soft-start the block spends a fixed number of cycles with the threshold current source at half strength and latches the over-current limit, clamping it to a built-in ceiling. The reference then ramps one code per STEP_DIV clocks up to the regulation target. Once regulation is reached, under-voltage detection stays off for a further interval equal to the ramp time. Under-voltage and over-current faults turn both switches off and start a timed hiccup that restarts from sampling. Over-voltage holds the low-side switch on, with hysteresis, instead of stopping conversion. All timing is counted in clock cycles set by parameters.

Top module: `buck_seq`

## Requirements
- R1: After reset, phase is idle (phase codes: 0 idle, 1 sampling, 2 soft-start, 3 run, 4 hiccup), gate_mode is 0, ref_code is 0 and thr_code equals TH_MAX.
- R2: A low supply_ok or a high shdn_req at a clock edge puts the block in idle with gate_mode 0 (gate codes: 0 both off, 1 normal switching, 2 low-side forced on) and ref_code 0 after that edge; when both are released, sampling begins one cycle later.
- R3: The sampling phase lasts SAMPLE_CYC cycles, isrc_half is high throughout it and low otherwise, and gate_mode is 0 during it.
- R4: At the end of sampling thr_code takes ocset_code, or TH_MAX when ocset_code exceeds TH_MAX (an open pin reads full scale); thr_code then holds its value in every other phase.
- R5: In soft-start ref_code starts at 0 and rises by one every STEP_DIV cycles; soft-start lasts REF_TARGET*STEP_DIV+1 cycles, after which the run phase presents ref_code equal to REF_TARGET and gate_mode 1.
- R6: uv_armed rises after REF_TARGET*STEP_DIV cycles of the run phase and is low in every other phase.
- R7: While uv_armed, fb_code below REF_TARGET/2 for UV_DEB consecutive cycles moves the block to hiccup with gate_mode 0 one cycle later; a shorter dip, or any dip while not armed, leaves the run phase unchanged.
- R8: In soft-start or run, fb_code above REF_TARGET*5/4 sets ov_active and gate_mode 2 one cycle later; they stay until fb_code falls below REF_TARGET*6/5, then gate_mode returns to 1.
- R9: oc_trip together with ls_phase while gate_mode is 1 moves the block to hiccup with gate_mode 0 one cycle later; oc_trip with ls_phase low has no effect.
- R10: Hiccup lasts HICCUP_CYC cycles with gate_mode 0 and is followed by a new sampling phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supply above its power-on threshold |
| shdn_req | input | 1 | Shutdown request (compensation node pulled low) |
| oc_trip | input | 1 | Low-side voltage drop above the latched limit |
| ls_phase | input | 1 | Low-side switch is in its conduction interval |
| fb_code | input | FB_W | Digitized feedback voltage |
| ocset_code | input | TH_W | Digitized voltage on the threshold-setting pin |
| ref_code | output | FB_W | Reference code for the error amplifier |
| gate_mode | output | 2 | 0 both off, 1 switching, 2 low-side forced on |
| phase | output | 3 | Current sequencer phase |
| thr_code | output | TH_W | Latched over-current limit |
| isrc_half | output | 1 | Threshold current source enabled at half strength |
| uv_armed | output | 1 | Under-voltage detection active |
| ov_active | output | 1 | Over-voltage hold in force |

## Verification
The startup sequence is run with an in-range threshold code and again with an over-range code, which separates a plain latch from the clamp, and the bench times sampling, ramp, arming delay and hiccup to the cycle so an off-by-one in any counter shows. Feedback is driven through a dip before arming, a dip one cycle short of the debounce and a full-length dip, which distinguishes arming, debounce length and the fault path. Over-voltage is driven above the rising level, into the hysteresis band and below the falling level to show that the release point differs from the set point. The over-current flag is raised with and without the low-side qualifier, and supply loss and shutdown are applied in sampling and soft-start to show the restart always begins at sampling.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SAMPLE = 3'd1,
      PH_SOFT   = 3'd2,
      PH_RUN    = 3'd3,
      PH_HICCUP = 3'd4
   } phase_t;

   typedef enum logic [1:0] {
      GM_OFF    = 2'd0,
      GM_SWITCH = 2'd1,
      GM_LOW_ON = 2'd2
   } gate_t;
endpackage

// File: rtl/buck_seq_ramp.sv
module buck_seq_ramp #(
   parameter int CODE_W   = 10,
   parameter int TARGET   = 512,
   parameter int STEP_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   output logic [CODE_W-1:0] code,
   output logic              done
);
   assign done = (code == CODE_W'(TARGET));

   generate
      if (STEP_DIV == 1) begin : g_nodiv
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          code <= '0;
            else if (!run)       code <= '0;
            else if (!done)      code <= code + 1'b1;
         end
      end else begin : g_div
         localparam int DIV_W = $clog2(STEP_DIV);
         logic [DIV_W-1:0] div;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div  <= '0;
               code <= '0;
            end else if (!run) begin
               div  <= '0;
               code <= '0;
            end else if (div == DIV_W'(STEP_DIV-1)) begin
               div <= '0;
               if (!done) code <= code + 1'b1;
            end else begin
               div <= div + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/buck_seq_ocset.sv
module buck_seq_ocset #(
   parameter int TH_W   = 8,
   parameter int TH_MAX = 175
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            capture,
   input  logic [TH_W-1:0] sample_in,
   output logic [TH_W-1:0] thr
);
   localparam logic [TH_W-1:0] CEIL = TH_W'(TH_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       thr <= CEIL;
      else if (capture) thr <= (sample_in > CEIL) ? CEIL : sample_in;
   end
endmodule

// File: rtl/buck_seq_fbmon.sv
module buck_seq_fbmon #(
   parameter int FB_W    = 10,
   parameter int UV_LVL  = 256,
   parameter int OV_RISE = 640,
   parameter int OV_FALL = 614,
   parameter int UV_DEB  = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [FB_W-1:0] fb,
   input  logic            uv_en,
   input  logic            ov_en,
   output logic            uv_fault,
   output logic            ov_active
);
   logic fb_low;
   assign fb_low = (fb < FB_W'(UV_LVL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ov_active <= 1'b0;
      else if (!ov_en)                 ov_active <= 1'b0;
      else if (fb > FB_W'(OV_RISE))    ov_active <= 1'b1;
      else if (fb < FB_W'(OV_FALL))    ov_active <= 1'b0;
   end

   generate
      if (UV_DEB == 0) begin : g_nodeb
         assign uv_fault = uv_en & fb_low;
      end else begin : g_deb
         localparam int CNT_W = $clog2(UV_DEB + 1);
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       cnt <= '0;
            else if (!(uv_en && fb_low))      cnt <= '0;
            else if (cnt != CNT_W'(UV_DEB))   cnt <= cnt + 1'b1;
         end
         assign uv_fault = (cnt == CNT_W'(UV_DEB));
      end
   endgenerate
endmodule

// File: rtl/buck_seq.sv
module buck_seq
   import buck_seq_pkg::*;
#(
   parameter int FB_W       = 10,
   parameter int TH_W       = 8,
   parameter int REF_TARGET = 512,
   parameter int STEP_DIV   = 4,
   parameter int SAMPLE_CYC = 64,
   parameter int UV_DEB     = 8,
   parameter int HICCUP_CYC = 256,
   parameter int TH_MAX     = 175
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            supply_ok,
   input  logic            shdn_req,
   input  logic            oc_trip,
   input  logic            ls_phase,
   input  logic [FB_W-1:0] fb_code,
   input  logic [TH_W-1:0] ocset_code,
   output logic [FB_W-1:0] ref_code,
   output logic [1:0]      gate_mode,
   output logic [2:0]      phase,
   output logic [TH_W-1:0] thr_code,
   output logic            isrc_half,
   output logic            uv_armed,
   output logic            ov_active
);
   localparam int SS_CYC  = REF_TARGET * STEP_DIV;
   localparam int UV_DLY  = SS_CYC;
   localparam int UV_LVL  = REF_TARGET / 2;
   localparam int OV_RISE = (REF_TARGET * 5) / 4;
   localparam int OV_FALL = (REF_TARGET * 6) / 5;
   localparam int TMR_MAX = (UV_DLY > SAMPLE_CYC) ?
                            ((UV_DLY > HICCUP_CYC) ? UV_DLY : HICCUP_CYC) :
                            ((SAMPLE_CYC > HICCUP_CYC) ? SAMPLE_CYC : HICCUP_CYC);
   localparam int TMR_W   = $clog2(TMR_MAX + 1);

   generate
      if (OV_RISE >= (1 << FB_W)) begin : g_bad_fbw
         $error("buck_seq: FB_W too narrow for the over-voltage level");
      end
      if (TH_MAX >= (1 << TH_W)) begin : g_bad_thw
         $error("buck_seq: TH_MAX does not fit TH_W");
      end
      if (SAMPLE_CYC < 1 || HICCUP_CYC < 1 || STEP_DIV < 1) begin : g_bad_time
         $error("buck_seq: timing parameters must be at least 1");
      end
   endgenerate

   phase_t           st, st_nx;
   logic [TMR_W-1:0] tmr;
   logic [FB_W-1:0]  ramp_code;
   logic             ramp_done;
   logic             uv_fault;
   logic             ov_hold;
   logic             oc_evt;
   logic             active;
   gate_t            gm;

   assign active = (st == PH_SOFT) || (st == PH_RUN);
   assign gm     = !active ? GM_OFF : (ov_hold ? GM_LOW_ON : GM_SWITCH);
   assign oc_evt = oc_trip && ls_phase && (gm == GM_SWITCH);

   always_comb begin
      st_nx = st;
      if (!supply_ok || shdn_req) begin
         st_nx = PH_IDLE;
      end else begin
         unique case (st)
            PH_IDLE:   st_nx = PH_SAMPLE;
            PH_SAMPLE: if (tmr == TMR_W'(SAMPLE_CYC-1)) st_nx = PH_SOFT;
            PH_SOFT:   if (oc_evt) st_nx = PH_HICCUP;
                       else if (ramp_done) st_nx = PH_RUN;
            PH_RUN:    if (oc_evt || uv_fault) st_nx = PH_HICCUP;
            PH_HICCUP: if (tmr == TMR_W'(HICCUP_CYC-1)) st_nx = PH_SAMPLE;
            default:   st_nx = PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= PH_IDLE;
         tmr <= '0;
      end else begin
         st <= st_nx;
         if (st_nx != st)                 tmr <= '0;
         else if (tmr != TMR_W'(TMR_MAX)) tmr <= tmr + 1'b1;
      end
   end

   buck_seq_ramp #(
      .CODE_W(FB_W), .TARGET(REF_TARGET), .STEP_DIV(STEP_DIV)
   ) u_ramp (
      .clk(clk), .rst_n(rst_n), .run(st == PH_SOFT),
      .code(ramp_code), .done(ramp_done)
   );

   buck_seq_ocset #(
      .TH_W(TH_W), .TH_MAX(TH_MAX)
   ) u_ocset (
      .clk(clk), .rst_n(rst_n),
      .capture((st == PH_SAMPLE) && (st_nx == PH_SOFT)),
      .sample_in(ocset_code), .thr(thr_code)
   );

   buck_seq_fbmon #(
      .FB_W(FB_W), .UV_LVL(UV_LVL), .OV_RISE(OV_RISE),
      .OV_FALL(OV_FALL), .UV_DEB(UV_DEB)
   ) u_fbmon (
      .clk(clk), .rst_n(rst_n), .fb(fb_code),
      .uv_en(uv_armed), .ov_en(active),
      .uv_fault(uv_fault), .ov_active(ov_hold)
   );

   assign uv_armed  = (st == PH_RUN) && (tmr >= TMR_W'(UV_DLY));
   assign ref_code  = (st == PH_RUN)  ? FB_W'(REF_TARGET) :
                      (st == PH_SOFT) ? ramp_code : '0;
   assign gate_mode = gm;
   assign phase     = st;
   assign isrc_half = (st == PH_SAMPLE);
   assign ov_active = ov_hold;
endmodule

// File: rtl/buck_seq_chk.sv
module buck_seq_chk #(
   parameter int FB_W       = 10,
   parameter int TH_W       = 8,
   parameter int REF_TARGET = 512,
   parameter int TH_MAX     = 175
) (
   input logic            clk,
   input logic            rst_n,
   input logic            supply_ok,
   input logic            shdn_req,
   input logic [FB_W-1:0] ref_code,
   input logic [1:0]      gate_mode,
   input logic [2:0]      phase,
   input logic [TH_W-1:0] thr_code,
   input logic            isrc_half,
   input logic            uv_armed,
   input logic            ov_active
);
   // R2
   stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!supply_ok || shdn_req) |=> (phase == 3'd0 && gate_mode == 2'd0));

   // R3
   bias_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      isrc_half |-> (gate_mode == 2'd0 && phase == 3'd1));

   // R4
   thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != 3'd1) |=> $stable(thr_code));

   // R4
   thr_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thr_code <= TH_W'(TH_MAX));

   // R5
   ref_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_code <= FB_W'(REF_TARGET));

   // R5
   ramp_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd2 && $past(phase) == 3'd2) |-> (ref_code >= $past(ref_code)));

   // R6
   arm_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uv_armed |-> (phase == 3'd3));

   // R8
   low_on_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_mode == 2'd2) |-> ov_active);

   // R8
   gate_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_mode != 2'd3);
endmodule

bind buck_seq buck_seq_chk #(
   .FB_W(FB_W), .TH_W(TH_W), .REF_TARGET(REF_TARGET), .TH_MAX(TH_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .shdn_req(shdn_req),
   .ref_code(ref_code), .gate_mode(gate_mode), .phase(phase),
   .thr_code(thr_code), .isrc_half(isrc_half), .uv_armed(uv_armed),
   .ov_active(ov_active)
);

// File: tb/buck_seq_tb.sv
`timescale 1ns/1ps
module buck_seq_tb;
   localparam int TGT  = 512;
   localparam int DIV  = 4;
   localparam int SMP  = 64;
   localparam int DEB  = 8;
   localparam int HIC  = 256;
   localparam int TMAX = 175;
   localparam int SS   = TGT * DIV;

   localparam int S_PH = 0, S_GM = 1, S_REF = 2, S_THR = 3, S_ARM = 4, S_OV = 5, S_ISRC = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       supply_ok = 1'b0;
   logic       shdn_req = 1'b0;
   logic       oc_trip = 1'b0;
   logic       ls_phase = 1'b0;
   logic [9:0] fb_code = '0;
   logic [7:0] ocset_code = 8'd100;
   logic [9:0] ref_code;
   logic [1:0] gate_mode;
   logic [2:0] phase;
   logic [7:0] thr_code;
   logic       isrc_half, uv_armed, ov_active;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   string q_req[$];
   int    q_sel[$];
   int    q_exp[$];

   always #10 clk = ~clk;

   buck_seq u_dut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .shdn_req(shdn_req),
      .oc_trip(oc_trip), .ls_phase(ls_phase), .fb_code(fb_code),
      .ocset_code(ocset_code), .ref_code(ref_code), .gate_mode(gate_mode),
      .phase(phase), .thr_code(thr_code), .isrc_half(isrc_half),
      .uv_armed(uv_armed), .ov_active(ov_active)
   );

   task automatic expect_o(input string r, input int sel, input int ex);
      q_req.push_back(r);
      q_sel.push_back(sel);
      q_exp.push_back(ex);
   endtask

   task automatic chk_val(input string r, input int act, input int ex);
      checks++;
      if (act != ex) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", r, act, ex);
      end
   endtask

   always @(negedge clk) begin
      while (q_sel.size() > 0) begin
         string r;
         int sel, ex, act;
         r   = q_req.pop_front();
         sel = q_sel.pop_front();
         ex  = q_exp.pop_front();
         case (sel)
            S_PH:    act = int'(phase);
            S_GM:    act = int'(gate_mode);
            S_REF:   act = int'(ref_code);
            S_THR:   act = int'(thr_code);
            S_ARM:   act = int'(uv_armed);
            S_OV:    act = int'(ov_active);
            default: act = int'(isrc_half);
         endcase
         chk_val(r, act, ex);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic count_phase(input int ph, output int n);
      n = 0;
      while (int'(phase) == ph && n < 20000) begin
         n++;
         tick(1);
      end
   endtask

   task automatic wait_phase(input int ph);
      int n = 0;
      while (int'(phase) != ph && n < 20000) begin
         n++;
         tick(1);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int n;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      expect_o("R1 phase", S_PH, 0);
      expect_o("R1 gate", S_GM, 0);
      expect_o("R1 ref", S_REF, 0);
      expect_o("R1 thr", S_THR, TMAX);
      tick(1);

      // R2, R3: release supply, sampling starts one cycle later
      supply_ok = 1'b1;
      tick(1);
      expect_o("R2 start", S_PH, 1);
      expect_o("R3 isrc", S_ISRC, 1);
      expect_o("R3 gate", S_GM, 0);
      count_phase(1, n);
      chk_val("R3 sample length", n, SMP);
      expect_o("R4 latch", S_THR, 100);
      expect_o("R5 soft", S_PH, 2);
      expect_o("R5 ref0", S_REF, 0);
      expect_o("R3 isrc off", S_ISRC, 0);
      fb_code = 10'd512;
      tick(40);
      expect_o("R5 mid ramp", S_REF, 40 / DIV);
      count_phase(2, n);
      chk_val("R5 soft length", n + 40, SS + 1);
      expect_o("R5 run", S_PH, 3);
      expect_o("R5 ref target", S_REF, TGT);
      expect_o("R5 gate", S_GM, 1);

      // R6, R7: arming delay with an early dip that must be ignored
      n = 0;
      while (!uv_armed && n < 20000) begin
         if (n == 5)  fb_code = 10'd100;
         if (n == 25) fb_code = 10'd512;
         n++;
         tick(1);
      end
      chk_val("R6 arm delay", n, SS);
      expect_o("R7 unarmed dip", S_PH, 3);

      // R8: over-voltage with hysteresis
      fb_code = 10'd700;
      tick(1);
      expect_o("R8 set", S_GM, 2);
      expect_o("R8 flag", S_OV, 1);
      fb_code = 10'd620;
      tick(3);
      expect_o("R8 band", S_GM, 2);
      fb_code = 10'd600;
      tick(1);
      expect_o("R8 release", S_GM, 1);
      expect_o("R8 flag off", S_OV, 0);

      // R7: short dip then full dip
      fb_code = 10'd100;
      tick(DEB - 1);
      fb_code = 10'd512;
      tick(2);
      expect_o("R7 short dip", S_PH, 3);
      fb_code = 10'd100;
      tick(DEB);
      expect_o("R7 before trip", S_PH, 3);
      tick(1);
      expect_o("R7 trip", S_PH, 4);
      expect_o("R7 gates off", S_GM, 0);
      expect_o("R4 hold in hiccup", S_THR, 100);
      fb_code = 10'd512;
      ocset_code = 8'd250;
      count_phase(4, n);
      chk_val("R10 hiccup length", n, HIC);
      expect_o("R10 resample", S_PH, 1);
      wait_phase(2);
      expect_o("R4 clamp", S_THR, TMAX);
      wait_phase(3);
      ocset_code = 8'd30;
      tick(3);
      expect_o("R4 hold in run", S_THR, TMAX);

      // R9: over-current qualified by low-side interval
      oc_trip = 1'b1;
      tick(3);
      expect_o("R9 unqualified", S_PH, 3);
      ls_phase = 1'b1;
      tick(1);
      expect_o("R9 trip", S_PH, 4);
      expect_o("R9 gates off", S_GM, 0);
      oc_trip = 1'b0;
      ls_phase = 1'b0;

      // R2: shutdown during sampling, supply loss during soft-start
      wait_phase(1);
      shdn_req = 1'b1;
      tick(1);
      expect_o("R2 shutdown", S_PH, 0);
      expect_o("R2 shutdown gate", S_GM, 0);
      tick(5);
      expect_o("R2 held idle", S_PH, 0);
      shdn_req = 1'b0;
      tick(1);
      expect_o("R2 restart", S_PH, 1);
      wait_phase(2);
      tick(10);
      supply_ok = 1'b0;
      tick(1);
      expect_o("R2 supply loss", S_PH, 0);
      expect_o("R2 supply gate", S_GM, 0);
      expect_o("R2 supply ref", S_REF, 0);
      supply_ok = 1'b1;
      tick(1);
      expect_o("R2 supply back", S_PH, 1);
      tick(2);
      finish_run();
   end
endmodule